// File: doc/BRIEF.md
# 3:2 Pulldown Cadence Lock Detector

This block looks at a stream of per-line difference scores and decides whether each video field repeats the field before it. Each score compares one line of the current field with the same line of the previous field. A field-start strobe closes the open field and opens a new one. When a field closes, the block compares the number of differing lines with a share of the field's line count. It then follows the five-field rhythm of 3:2 pulldown, in which one field in five is a repeat. A confidence count, with separate lock and unlock thresholds, drives a lock flag that downstream reverse-telecine logic uses. The current cadence phase is also provided, so that the weaver knows which neighbouring field to pair with.

Line scores arrive on a valid/ready interface. The block never applies back-pressure: `line_ready` is always high, and every cycle with `line_valid` high transfers one score. `field_start` is a plain strobe. A line presented in the same cycle as `field_start` belongs to the new field. Threshold and shift inputs are plain configuration levels, and software tunes them using `diff_count`, the differing-line count of the last completed field.

Top module: `cadence_lock_detector`

## Requirements
- R1: After reset, `lock` is 0, `phase` is 0 and `diff_count` is 0.
- R2: A transferred line counts as differing when `line_score >> cfg_noise_shift` is greater than or equal to `cfg_diff_thr`. Cycles with `line_valid` low are not counted.
- R3: `diff_count` takes the differing-line count of the closing field on the edge where `field_start` closes it, and holds that value until the next close.
- R4: The first `field_start` after reset only opens a field and evaluates nothing. Lines transferred before it are ignored.
- R5: A closing field is a repeat when its differing-line count is strictly less than its transferred-line count shifted right by `cfg_ratio_shift`. An equal count is not a repeat.
- R6: `phase` is 0 on a repeat field and otherwise advances by one per closed field, wrapping from 4 to 0. A repeat that arrives while the next phase would not be 0 clears confidence.
- R7: A repeat that arrives when the next phase is 0 increments confidence, saturating at its maximum.
- R8: A non-repeat field whose next phase is 0 (a missing repeat) decrements confidence by one, stopping at 0. Other non-repeat fields leave it unchanged.
- R9: When unlocked, `lock` sets at a field close where confidence reaches `cfg_lock_thr`. When locked, it clears at a close where confidence is at or below `cfg_unlock_thr`. Otherwise it holds.
- R10: `line_ready` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| field_start | input | 1 | Closes the open field and opens a new one |
| line_valid | input | 1 | A line score is presented |
| line_ready | output | 1 | Always 1 |
| line_score | input | SCORE_W | Raw difference score of one line |
| cfg_noise_shift | input | SHIFT_W | Right shift applied to each score |
| cfg_diff_thr | input | THR_W | Shifted-score threshold for a differing line |
| cfg_ratio_shift | input | RATIO_W | Shift applied to the line count to get the repeat limit |
| cfg_lock_thr | input | CONF_W | Confidence needed to lock |
| cfg_unlock_thr | input | CONF_W | Confidence at or below which lock drops |
| diff_count | output | LINE_W | Differing lines in the last completed field |
| phase | output | 3 | Cadence phase, 0 to 4, where 0 is the repeat field |
| lock | output | 1 | Cadence lock flag |

## Verification
The hardest state to reach is the hysteresis band: locked, with confidence between the two thresholds. Getting there takes six aligned five-field cycles, followed by a missing repeat that sits exactly on the ratio boundary. The stimulus builds whole fields from a chosen number of lines and differing lines. Scores sit exactly at the threshold or one below it, with invalid high-score gaps mixed in. This lets it step confidence up to lock, hold lock through one missing repeat, release it with a second, and then force a resync with an early repeat.

// File: rtl/cadence_pkg.sv
package cadence_pkg;
  localparam int unsigned CAD_PHASES = 5;
  typedef logic [2:0] phase_t;

  function automatic phase_t phase_adv(phase_t p);
    return (p == phase_t'(CAD_PHASES - 1)) ? phase_t'(0) : phase_t'(p + 3'd1);
  endfunction
endpackage

// File: rtl/cadence_line_acc.sv
module cadence_line_acc #(
  parameter int SCORE_W = 16,
  parameter int LINE_W  = 12,
  parameter int SHIFT_W = 4,
  parameter int THR_W   = 8,
  parameter int RATIO_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               field_start,
  input  logic               line_valid,
  input  logic [SCORE_W-1:0] line_score,
  input  logic [SHIFT_W-1:0] cfg_shift,
  input  logic [THR_W-1:0]   cfg_thr,
  input  logic [RATIO_W-1:0] cfg_ratio,
  output logic               field_close,
  output logic               field_repeat,
  output logic [LINE_W-1:0]  diff_count
);
  localparam logic [LINE_W-1:0] LINE_MAX = '1;

  logic              open_q;
  logic [LINE_W-1:0] lines_q, diff_q, dc_q;
  logic [SCORE_W-1:0] shifted;
  logic               is_diff;
  logic [LINE_W-1:0]  need;

  assign shifted      = line_score >> cfg_shift;
  assign is_diff      = shifted >= SCORE_W'(cfg_thr);
  assign need         = lines_q >> cfg_ratio;
  assign field_close  = field_start & open_q;
  assign field_repeat = diff_q < need;
  assign diff_count   = dc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      lines_q <= '0;
      diff_q  <= '0;
      dc_q    <= '0;
    end else if (field_start) begin
      open_q  <= 1'b1;
      lines_q <= line_valid ? LINE_W'(1) : '0;
      diff_q  <= (line_valid && is_diff) ? LINE_W'(1) : '0;
      if (open_q) dc_q <= diff_q;
    end else if (line_valid && open_q && lines_q != LINE_MAX) begin
      lines_q <= lines_q + LINE_W'(1);
      if (is_diff) diff_q <= diff_q + LINE_W'(1);
    end
  end

  a_r2_diff_le_lines: assert property (@(posedge clk) disable iff (!rst_n)
    diff_q <= lines_q);
  a_r3_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !field_close |=> $stable(dc_q));
  a_r4_idle_until_open: assert property (@(posedge clk) disable iff (!rst_n)
    !open_q |=> (lines_q <= LINE_W'(1)));
endmodule

// File: rtl/cadence_phase_track.sv
module cadence_phase_track
  import cadence_pkg::*;
#(
  parameter int CONF_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt,
  input  logic              rep,
  input  logic [CONF_W-1:0] cfg_lock_thr,
  input  logic [CONF_W-1:0] cfg_unlock_thr,
  output phase_t            phase,
  output logic              lock
);
  localparam logic [CONF_W-1:0] CONF_MAX = '1;

  phase_t            phase_q, phase_n, next_p;
  logic [CONF_W-1:0] conf_q, conf_n;
  logic              lock_q, lock_n;

  always_comb begin
    next_p = phase_adv(phase_q);
    if (rep) begin
      phase_n = phase_t'(0);
      if (next_p == phase_t'(0))
        conf_n = (conf_q == CONF_MAX) ? conf_q : conf_q + CONF_W'(1);
      else
        conf_n = '0;
    end else begin
      phase_n = next_p;
      conf_n  = (next_p == phase_t'(0) && conf_q != '0) ? conf_q - CONF_W'(1) : conf_q;
    end
    lock_n = lock_q;
    if (!lock_q && conf_n >= cfg_lock_thr)      lock_n = 1'b1;
    else if (lock_q && conf_n <= cfg_unlock_thr) lock_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
      conf_q  <= '0;
      lock_q  <= 1'b0;
    end else if (evt) begin
      phase_q <= phase_n;
      conf_q  <= conf_n;
      lock_q  <= lock_n;
    end
  end

  assign phase = phase_q;
  assign lock  = lock_q;

  a_r6_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= 3'd4);
  a_r6_repeat_resync: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && rep) |=> phase_q == 3'd0);
  a_r7_quiet_between: assert property (@(posedge clk) disable iff (!rst_n)
    !evt |=> ($stable(conf_q) && $stable(phase_q) && $stable(lock_q)));
  a_r9_lock_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> conf_q >= cfg_lock_thr);
  a_r9_lock_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_q) |-> conf_q <= cfg_unlock_thr);
endmodule

// File: rtl/cadence_lock_detector.sv
module cadence_lock_detector
  import cadence_pkg::*;
#(
  parameter int SCORE_W = 16,
  parameter int LINE_W  = 12,
  parameter int SHIFT_W = 4,
  parameter int THR_W   = 8,
  parameter int RATIO_W = 4,
  parameter int CONF_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               field_start,
  input  logic               line_valid,
  output logic               line_ready,
  input  logic [SCORE_W-1:0] line_score,
  input  logic [SHIFT_W-1:0] cfg_noise_shift,
  input  logic [THR_W-1:0]   cfg_diff_thr,
  input  logic [RATIO_W-1:0] cfg_ratio_shift,
  input  logic [CONF_W-1:0]  cfg_lock_thr,
  input  logic [CONF_W-1:0]  cfg_unlock_thr,
  output logic [LINE_W-1:0]  diff_count,
  output logic [2:0]         phase,
  output logic               lock
);
  logic   close_w, repeat_w;
  phase_t phase_w;

  assign line_ready = 1'b1;

  cadence_line_acc #(
    .SCORE_W(SCORE_W), .LINE_W(LINE_W), .SHIFT_W(SHIFT_W),
    .THR_W(THR_W), .RATIO_W(RATIO_W)
  ) u_acc (
    .clk(clk), .rst_n(rst_n), .field_start(field_start),
    .line_valid(line_valid), .line_score(line_score),
    .cfg_shift(cfg_noise_shift), .cfg_thr(cfg_diff_thr), .cfg_ratio(cfg_ratio_shift),
    .field_close(close_w), .field_repeat(repeat_w), .diff_count(diff_count)
  );

  cadence_phase_track #(.CONF_W(CONF_W)) u_track (
    .clk(clk), .rst_n(rst_n), .evt(close_w), .rep(repeat_w),
    .cfg_lock_thr(cfg_lock_thr), .cfg_unlock_thr(cfg_unlock_thr),
    .phase(phase_w), .lock(lock)
  );

  assign phase = phase_w;
endmodule

// File: tb/tb_cadence_lock_detector.sv
module tb_cadence_lock_detector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        field_start = 1'b0;
  logic        line_valid = 1'b0;
  logic        line_ready;
  logic [15:0] line_score = '0;
  logic [3:0]  cfg_noise_shift = 4'd5;
  logic [7:0]  cfg_diff_thr = 8'd16;
  logic [3:0]  cfg_ratio_shift = 4'd4;
  logic [3:0]  cfg_lock_thr = 4'd6;
  logic [3:0]  cfg_unlock_thr = 4'd4;
  logic [11:0] diff_count;
  logic [2:0]  phase;
  logic        lock;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  int m_open, m_lines, m_diff, m_dc, m_phase, m_conf, m_lock;

  always #2 clk = ~clk;

  cadence_lock_detector dut (
    .clk(clk), .rst_n(rst_n), .field_start(field_start), .line_valid(line_valid),
    .line_ready(line_ready), .line_score(line_score),
    .cfg_noise_shift(cfg_noise_shift), .cfg_diff_thr(cfg_diff_thr),
    .cfg_ratio_shift(cfg_ratio_shift), .cfg_lock_thr(cfg_lock_thr),
    .cfg_unlock_thr(cfg_unlock_thr), .diff_count(diff_count), .phase(phase), .lock(lock)
  );

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0d exp=%0d t=%0t", tag, got, exp, $time);
    end
  endtask

  // Behavioural reference model
  always @(posedge clk) begin
    bit rep;
    int np;
    if (!rst_n) begin
      m_open = 0; m_lines = 0; m_diff = 0; m_dc = 0;
      m_phase = 0; m_conf = 0; m_lock = 0;
    end else begin
      if (field_start) begin
        if (m_open != 0) begin
          rep = m_diff < (m_lines >> cfg_ratio_shift);
          np = (m_phase + 1) % 5;
          m_dc = m_diff;
          if (rep) begin
            if (np == 0) m_conf = (m_conf < 15) ? m_conf + 1 : 15;
            else m_conf = 0;
            m_phase = 0;
          end else begin
            m_phase = np;
            if (np == 0 && m_conf > 0) m_conf = m_conf - 1;
          end
          if (m_lock == 0 && m_conf >= int'(cfg_lock_thr)) m_lock = 1;
          else if (m_lock != 0 && m_conf <= int'(cfg_unlock_thr)) m_lock = 0;
        end
        m_open = 1; m_lines = 0; m_diff = 0;
      end
      if (line_valid && m_open != 0) begin
        m_lines++;
        if ((int'(line_score) >> cfg_noise_shift) >= int'(cfg_diff_thr)) m_diff++;
      end
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R9 lock (model)", int'(lock), m_lock);
      chk("R6 phase (model)", int'(phase), m_phase);
      chk("R3 diff_count (model)", int'(diff_count), m_dc);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog got=%0d exp=%0d", cycles, 200000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic field(int nl, int nd);
    int ds;
    ds = int'(cfg_diff_thr) << cfg_noise_shift;
    for (int i = 0; i < nl; i++) begin
      if (i % 4 == 3) begin
        line_valid = 1'b0; line_score = '1;
        @(negedge clk);
      end
      line_valid = 1'b1;
      line_score = 16'((i < nd) ? ds : ds - 1);
      @(negedge clk);
    end
    line_valid = 1'b0; line_score = '0; field_start = 1'b1;
    @(negedge clk);
    field_start = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 lock", int'(lock), 0);
    chk("R1 phase", int'(phase), 0);
    chk("R1 diff_count", int'(diff_count), 0);
    chk("R10 ready", int'(line_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    // R4: lines before the first field_start are ignored
    for (int i = 0; i < 3; i++) begin
      line_valid = 1'b1; line_score = 16'd512; @(negedge clk);
    end
    line_valid = 1'b0; field_start = 1'b1; @(negedge clk); field_start = 1'b0;
    chk("R4 phase after opening", int'(phase), 0);
    chk("R4 diff_count after opening", int'(diff_count), 0);
    field(32, 5);
    chk("R2 diff_count boundary scores", int'(diff_count), 5);
    chk("R3 phase advance", int'(phase), 1);
    field(32, 1);
    chk("R5 repeat below limit", int'(diff_count), 1);
    chk("R6 resync to phase 0", int'(phase), 0);
    for (int k = 1; k <= 6; k++) begin
      for (int j = 0; j < 4; j++) field(32, 20);
      chk("R6 phase wraps", int'(phase), 4);
      field(32, 0);
      chk("R7 aligned repeat phase", int'(phase), 0);
      chk("R9 lock after confidence steps", int'(lock), (k >= 6) ? 1 : 0);
    end
    for (int j = 0; j < 4; j++) field(32, 20);
    field(32, 2);
    chk("R5 equal count is not repeat", int'(diff_count), 2);
    chk("R8 missing repeat keeps phase 0", int'(phase), 0);
    chk("R9 hysteresis holds lock", int'(lock), 1);
    for (int j = 0; j < 4; j++) field(32, 20);
    field(32, 3);
    chk("R8 second miss drops lock", int'(lock), 0);
    field(32, 20);
    chk("R6 phase 1", int'(phase), 1);
    field(32, 0);
    chk("R6 early repeat resync", int'(phase), 0);
    cfg_noise_shift = 4'd0;
    field(32, 7);
    chk("R2 zero shift count", int'(diff_count), 7);
    chk("R10 ready held", int'(line_ready), 1);
    repeat (4) @(negedge clk);
    chk("R3 count holds", int'(diff_count), 7);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule